// File: doc/BRIEF.md
# Programmed-IO Ethernet Frame Controller

This block is a memory-mapped network controller in which the processor moves every frame byte by byte through data-port registers. A received frame arrives on an inbound byte stream and lands in a single-frame receive buffer. Software then learns its length from a count register and drains it one byte per read. To transmit, software programs a frame length and writes that many bytes into a transmit data port. The frame leaves on an outbound byte stream on its own once the last byte has been written.

A small interrupt-control word holds three flags: transmit done, receive done and a self-test flag. The level interrupt follows that word. Writes to the interrupt-control word are decoded by priority. The self-test write resets the whole controller and leaves only the test flag standing, and the test flag clears itself when the word is read. A busy flag gates the receive side, so that no new frame can overwrite data that software has not yet acknowledged.

The bus is a simple single-cycle register port. Read data is combinational from the current state, and read side effects such as pointer advances and flag clears take effect at the clock edge that ends the access.

Top module: `pio_eth_ctrl`

## Requirements
- R1: Only the low 6 address bits are decoded. The register offsets are: identification words at 0x00 and 0x04 (the values of parameters ID_WORD0 and ID_WORD1), busy at 0x08, receive count at 0x0C, transmit count at 0x10, interrupt control at 0x14, interrupt info at 0x18, receive data port at 0x1C and transmit data port at 0x20.
- R2: Interrupt control holds transmit done in bit 0, receive done in bit 1 and the test flag in bit 31, and all other bits read 0. The irq output is 1 exactly when any of these bits is set.
- R3: A read of interrupt control returns its value before the access, and the test flag is 0 afterwards.
- R4: A write to interrupt control is handled by priority. If data bit 0 is set, only transmit done is cleared. Otherwise, if bit 1 is set, only receive done is cleared. Otherwise, if bit 31 is set, the controller is soft-reset to the R5 state and the test flag is then set. A write with none of these bits changes no flag. After every such write, busy equals 1 if interrupt control is nonzero and 0 otherwise.
- R5: After reset, busy reads 1 and the receive count, transmit count and interrupt control read 0. irq, rx_ready and tx_valid are 0.
- R6: A write to transmit count loads the value if it is at most FRAME_MAX and loads 0 otherwise. It always restarts the transmit write position at byte 0.
- R7: A write to the transmit data port stores bits 7:0 at the write position and advances it. The write that makes the position equal the transmit count launches the frame: transmit count and position return to 0, transmit done and busy are set, and tx_valid rises in the next cycle with the stored bytes in write order.
- R8: A read of the receive data port with a nonzero receive count returns the next buffered byte in arrival order and decrements the count. With a count of 0, the read returns 0 and changes nothing.
- R9: Between frames, rx_ready is 1 only when busy is 0 and the receive count is below FRAME_MAX. The first accepted byte sets busy. Once a frame is in progress, rx_ready stays 1 until its last byte. The last byte loads the receive count with the stored length, restarts the read position and sets receive done.
- R10: Interrupt info and the transmit data port read 0. Writes to the identification, busy, receive count, interrupt info and receive data offsets change nothing.
- R11: Bytes of an inbound frame beyond FRAME_MAX are accepted and dropped, and the receive count then equals FRAME_MAX.
- R12: Transmit data writes are ignored while the transmit count is 0 or while a frame is on the outbound stream. tx_data and tx_last hold while tx_valid is 1 and tx_ready is 0, and tx_last marks the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address; only bits 5:0 decoded |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Inbound byte valid |
| rx_data | input | 8 | Inbound byte |
| rx_last | input | 1 | Inbound byte closes the frame |
| rx_ready | output | 1 | Controller takes the inbound byte |
| tx_valid | output | 1 | Outbound byte valid |
| tx_data | output | 8 | Outbound byte |
| tx_last | output | 1 | Outbound byte closes the frame |
| tx_ready | input | 1 | Sink takes the outbound byte |

## Verification
The bench builds the controller with FRAME_MAX set to 16 and ADDR_W set to 8. A frame limit of 16 brings an over-length inbound frame that saturates the count, a full-length transmit, and a receive count pinned at the limit that blocks rx_ready within a few dozen cycles. The 8-bit address lets the bench access registers through aliases with bit 6 set. The identification words are passed in explicitly, so the bench knows their expected values.

// File: rtl/pio_eth_pkg.sv
package pio_eth_pkg;

    // Register offsets after the address is reduced to 6 bits
    localparam logic [5:0] OFS_ID0    = 6'h00;
    localparam logic [5:0] OFS_ID1    = 6'h04;
    localparam logic [5:0] OFS_BUSY   = 6'h08;
    localparam logic [5:0] OFS_RXCNT  = 6'h0C;
    localparam logic [5:0] OFS_TXCNT  = 6'h10;
    localparam logic [5:0] OFS_IRQCTL = 6'h14;
    localparam logic [5:0] OFS_INFO   = 6'h18;
    localparam logic [5:0] OFS_RXPORT = 6'h1C;
    localparam logic [5:0] OFS_TXPORT = 6'h20;

    // Bit positions inside the interrupt-control word
    localparam int IC_TXD = 0;
    localparam int IC_RXD = 1;
    localparam int IC_TST = 31;

    typedef struct packed {
        logic tst;
        logic rxd;
        logic txd;
    } irqctl_t;

    function automatic logic [31:0] irqctl_word(irqctl_t ic);
        logic [31:0] w;
        w         = '0;
        w[IC_TXD] = ic.txd;
        w[IC_RXD] = ic.rxd;
        w[IC_TST] = ic.tst;
        return w;
    endfunction

endpackage

// File: rtl/pio_eth_bytebuf.sv
module pio_eth_bytebuf #(
    parameter int DEPTH = 1514,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_byte,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_byte;
        end
    end

    assign rd_byte = mem[rd_addr];

endmodule

// File: rtl/pio_eth_rdmux.sv
module pio_eth_rdmux
    import pio_eth_pkg::*;
#(
    parameter int          CW       = 11,
    parameter logic [31:0] ID_WORD0 = 32'h0,
    parameter logic [31:0] ID_WORD1 = 32'h0
) (
    input  logic [5:0]    ofs,
    input  logic          busy,
    input  logic [CW-1:0] rx_cnt,
    input  logic [CW-1:0] tx_cnt,
    input  irqctl_t       ic,
    input  logic [7:0]    rx_byte,
    output logic [31:0]   rdata
);

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_ID0:    rdata = ID_WORD0;
            OFS_ID1:    rdata = ID_WORD1;
            OFS_BUSY:   rdata = {31'b0, busy};
            OFS_RXCNT:  rdata = 32'(rx_cnt);
            OFS_TXCNT:  rdata = 32'(tx_cnt);
            OFS_IRQCTL: rdata = irqctl_word(ic);
            OFS_RXPORT: rdata = (rx_cnt != '0) ? {24'b0, rx_byte} : 32'b0;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/pio_eth_ctrl.sv
module pio_eth_ctrl
    import pio_eth_pkg::*;
#(
    parameter int          FRAME_MAX = 1514,
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] ID_WORD0  = 32'h4554_4850,
    parameter logic [31:0] ID_WORD1  = 32'h494F_3031
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);

    localparam int PW = $clog2(FRAME_MAX);
    localparam int CW = $clog2(FRAME_MAX + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FRAME_MAX);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] rx_cnt;
        logic [PW-1:0] rx_rptr;
        logic [CW-1:0] rx_wcnt;
        logic          rx_act;
        logic [CW-1:0] tx_cnt;
        logic [CW-1:0] tx_wptr;
        logic          sending;
        logic [CW-1:0] snd_len;
        logic [PW-1:0] snd_idx;
        irqctl_t       ic;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s      = '0;
        s.busy = 1'b1;
        return s;
    endfunction

    state_t q, d;

    logic [5:0]    ofs;
    logic          addr_unused;
    logic          rx_we, tx_we;
    logic [PW-1:0] rx_waddr, tx_waddr;
    logic [CW-1:0] rx_pos;
    logic [7:0]    rx_rd_byte, tx_rd_byte;
    logic          snd_final;
    logic [CW-1:0] rx_cnt_q, tx_cnt_q;
    logic [2:0]    ic_q;

    assign ofs         = bus_addr[5:0];
    assign addr_unused = ^bus_addr;

    assign snd_final = (CW'(q.snd_idx) == q.snd_len - CW'(1));
    assign rx_ready  = q.rx_act | (~q.busy & (q.rx_cnt < LIMIT));
    assign tx_valid  = q.sending;
    assign tx_data   = tx_rd_byte;
    assign tx_last   = q.sending & snd_final;
    assign irq       = q.ic.tst | q.ic.rxd | q.ic.txd;

    assign rx_cnt_q = q.rx_cnt;
    assign tx_cnt_q = q.tx_cnt;
    assign ic_q     = {q.ic.tst, q.ic.rxd, q.ic.txd};

    always_comb begin
        d        = q;
        rx_we    = 1'b0;
        rx_waddr = '0;
        tx_we    = 1'b0;
        tx_waddr = '0;
        rx_pos   = '0;

        // Inbound stream: capture up to FRAME_MAX bytes, drop the rest
        if (rx_valid && rx_ready) begin
            rx_pos = q.rx_act ? q.rx_wcnt : '0;
            if (!q.rx_act) begin
                d.busy   = 1'b1;
                d.rx_act = 1'b1;
            end
            if (rx_pos < LIMIT) begin
                rx_we    = 1'b1;
                rx_waddr = rx_pos[PW-1:0];
                rx_pos   = rx_pos + CW'(1);
            end
            d.rx_wcnt = rx_pos;
            if (rx_last) begin
                d.rx_cnt  = rx_pos;
                d.rx_rptr = '0;
                d.rx_act  = 1'b0;
                d.ic.rxd  = 1'b1;
            end
        end

        // Outbound stream
        if (q.sending && tx_ready) begin
            if (snd_final) begin
                d.sending = 1'b0;
            end else begin
                d.snd_idx = q.snd_idx + PW'(1);
            end
        end

        // Read side effects
        if (bus_rd) begin
            if (ofs == OFS_RXPORT && q.rx_cnt != '0) begin
                d.rx_cnt  = q.rx_cnt - CW'(1);
                d.rx_rptr = q.rx_rptr + PW'(1);
            end
            if (ofs == OFS_IRQCTL) begin
                d.ic.tst = 1'b0;
            end
        end

        // Writes
        if (bus_wr) begin
            case (ofs)
                OFS_TXCNT: begin
                    d.tx_cnt  = (bus_wdata <= 32'(FRAME_MAX)) ? bus_wdata[CW-1:0] : '0;
                    d.tx_wptr = '0;
                end
                OFS_TXPORT: begin
                    if (q.tx_cnt != '0 && !q.sending) begin
                        tx_we    = 1'b1;
                        tx_waddr = q.tx_wptr[PW-1:0];
                        if (q.tx_wptr + CW'(1) == q.tx_cnt) begin
                            d.sending = 1'b1;
                            d.snd_len = q.tx_cnt;
                            d.snd_idx = '0;
                            d.tx_cnt  = '0;
                            d.tx_wptr = '0;
                            d.ic.txd  = 1'b1;
                            d.busy    = 1'b1;
                        end else begin
                            d.tx_wptr = q.tx_wptr + CW'(1);
                        end
                    end
                end
                OFS_IRQCTL: begin
                    if (bus_wdata[IC_TXD]) begin
                        d.ic.txd = 1'b0;
                    end else if (bus_wdata[IC_RXD]) begin
                        d.ic.rxd = 1'b0;
                    end else if (bus_wdata[IC_TST]) begin
                        d        = reset_state();
                        d.ic.tst = 1'b1;
                    end
                    d.busy = d.ic.tst | d.ic.rxd | d.ic.txd;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= reset_state();
        end else begin
            q <= d;
        end
    end

    pio_eth_bytebuf #(.DEPTH(FRAME_MAX), .AW(PW)) u_rxbuf (
        .clk     (clk),
        .wr_en   (rx_we),
        .wr_addr (rx_waddr),
        .wr_byte (rx_data),
        .rd_addr (q.rx_rptr),
        .rd_byte (rx_rd_byte)
    );

    pio_eth_bytebuf #(.DEPTH(FRAME_MAX), .AW(PW)) u_txbuf (
        .clk     (clk),
        .wr_en   (tx_we),
        .wr_addr (tx_waddr),
        .wr_byte (bus_wdata[7:0]),
        .rd_addr (q.snd_idx),
        .rd_byte (tx_rd_byte)
    );

    pio_eth_rdmux #(.CW(CW), .ID_WORD0(ID_WORD0), .ID_WORD1(ID_WORD1)) u_rdmux (
        .ofs     (ofs),
        .busy    (q.busy),
        .rx_cnt  (q.rx_cnt),
        .tx_cnt  (q.tx_cnt),
        .ic      (q.ic),
        .rx_byte (rx_rd_byte),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/pio_eth_chk.sv
module pio_eth_chk
    import pio_eth_pkg::*;
#(
    parameter int FRAME_MAX = 1514,
    parameter int ADDR_W    = 8,
    parameter int CW        = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              tx_ready,
    input logic [CW-1:0]     rx_cnt_q,
    input logic [CW-1:0]     tx_cnt_q,
    input logic [2:0]        ic_q
);

    logic [5:0] ofs;
    logic       soft_rst;
    assign ofs      = bus_addr[5:0];
    assign soft_rst = bus_wr && ofs == OFS_IRQCTL && !bus_wdata[IC_TXD]
                      && !bus_wdata[IC_RXD] && bus_wdata[IC_TST];

    // R2
    irq_matches_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ofs == OFS_IRQCTL) |-> (irq == (bus_rdata != 32'b0)));

    // R3
    tst_clr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ofs == OFS_IRQCTL) |=> !ic_q[2]);

    // R4
    txd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ofs == OFS_IRQCTL && bus_wdata[IC_TXD]) |=> !ic_q[0]);

    // R6
    txcnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ofs == OFS_TXCNT && bus_wdata > 32'(FRAME_MAX)) |=> (tx_cnt_q == '0));

    // R7
    tx_launch_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> irq);

    // R8
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ofs == OFS_RXPORT && rx_cnt_q == '0) |-> (bus_rdata == 32'b0));

    // R11
    rx_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt_q <= CW'(FRAME_MAX)));

    // R12
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !soft_rst) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

endmodule

bind pio_eth_ctrl pio_eth_chk #(
    .FRAME_MAX (FRAME_MAX),
    .ADDR_W    (ADDR_W),
    .CW        (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready),
    .rx_cnt_q  (rx_cnt_q),
    .tx_cnt_q  (tx_cnt_q),
    .ic_q      (ic_q)
);

// File: tb/tb_pio_eth_ctrl.sv
module tb_pio_eth_ctrl;

    localparam int          MAX = 16;
    localparam logic [31:0] ID0 = 32'h1357_9BDF;
    localparam logic [31:0] ID1 = 32'h2468_ACE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    always #5 clk = ~clk;

    pio_eth_ctrl #(.FRAME_MAX(MAX), .ADDR_W(8), .ID_WORD0(ID0), .ID_WORD1(ID1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // Behavioural reference state
    bit          m_busy;
    bit          m_rxact;
    logic [31:0] m_int;
    int          m_txcnt;
    logic [7:0]  m_rxq[$];
    logic [7:0]  m_rxfrm[$];
    logic [7:0]  m_txbuf[$];
    logic [7:0]  m_sendq[$];
    logic [7:0]  got[$];
    logic [31:0] last_rd;
    bit          rx_took;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_busy = 1; m_rxact = 0; m_int = '0; m_txcnt = 0;
        m_rxq.delete(); m_rxfrm.delete(); m_txbuf.delete(); m_sendq.delete();
    endtask

    function automatic bit exp_rdy();
        return m_rxact || (!m_busy && m_rxq.size() < MAX);
    endfunction

    function automatic logic [31:0] exp_rdata(logic [5:0] a);
        case (a)
            6'h00: return ID0;
            6'h04: return ID1;
            6'h08: return {31'b0, m_busy};
            6'h0C: return 32'(m_rxq.size());
            6'h10: return 32'(m_txcnt);
            6'h14: return m_int;
            6'h1C: return (m_rxq.size() != 0) ? {24'b0, m_rxq[0]} : 32'b0;
            default: return 32'b0;
        endcase
    endfunction

    task automatic model_step();
        bit pre_send = (m_sendq.size() != 0);
        bit rdy      = exp_rdy();
        int pre_rxn  = m_rxq.size();
        logic [5:0] a = bus_addr[5:0];
        if (rx_valid && rdy) begin
            if (!m_rxact) begin m_busy = 1; m_rxact = 1; m_rxfrm.delete(); end
            if (m_rxfrm.size() < MAX) m_rxfrm.push_back(rx_data);
            if (rx_last) begin m_rxq = m_rxfrm; m_rxact = 0; m_int[1] = 1'b1; end
        end
        if (pre_send && tx_ready) void'(m_sendq.pop_front());
        if (bus_rd) begin
            if (a == 6'h1C && pre_rxn > 0) void'(m_rxq.pop_front());
            if (a == 6'h14) m_int[31] = 1'b0;
        end
        if (bus_wr) begin
            if (a == 6'h10) begin
                m_txcnt = (bus_wdata <= MAX) ? int'(bus_wdata) : 0;
                m_txbuf.delete();
            end else if (a == 6'h20) begin
                if (m_txcnt != 0 && !pre_send) begin
                    m_txbuf.push_back(bus_wdata[7:0]);
                    if (m_txbuf.size() == m_txcnt) begin
                        m_sendq = m_txbuf; m_txbuf.delete(); m_txcnt = 0;
                        m_int[0] = 1'b1; m_busy = 1;
                    end
                end
            end else if (a == 6'h14) begin
                if (bus_wdata[0]) m_int[0] = 1'b0;
                else if (bus_wdata[1]) m_int[1] = 1'b0;
                else if (bus_wdata[31]) begin model_reset(); m_int[31] = 1'b1; end
                m_busy = (m_int != 0);
            end
        end
    endtask

    // One clock: compare outputs after the inputs settle, then advance both sides
    task automatic tick();
        #1;
        chk("R2", {31'b0, irq}, {31'b0, m_int != 0});
        chk("R9", {31'b0, rx_ready}, {31'b0, exp_rdy()});
        chk("R12", {31'b0, tx_valid}, {31'b0, m_sendq.size() != 0});
        if (m_sendq.size() != 0) begin
            chk("R7", {24'b0, tx_data}, {24'b0, m_sendq[0]});
            chk("R12", {31'b0, tx_last}, {31'b0, m_sendq.size() == 1});
        end
        if (bus_rd) begin
            chk("R1", bus_rdata, exp_rdata(bus_addr[5:0]));
            last_rd = bus_rdata;
        end
        rx_took = rx_valid && rx_ready;
        if (tx_valid && tx_ready) got.push_back(tx_data);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
        bus_rd = 1; bus_addr = a;
        tick();
        bus_rd = 0;
        chk(req, last_rd, exp);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] v);
        bus_wr = 1; bus_addr = a; bus_wdata = v;
        tick();
        bus_wr = 0;
    endtask

    task automatic rx_frame(int n, logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_data = base + 8'(i); rx_last = (i == n - 1);
            do tick(); while (!rx_took);
        end
        rx_valid = 0; rx_last = 0;
    endtask

    task automatic drain(int n);
        for (int i = 0; i < 40 && got.size() < n; i++) tick();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R5 reset state
        chk("R5", {29'b0, irq, rx_ready, tx_valid}, 32'b0);
        rd(8'h08, 32'd1, "R5");
        rd(8'h0C, 32'd0, "R5");
        rd(8'h10, 32'd0, "R5");
        rd(8'h14, 32'd0, "R5");
        // R1 identification through an alias above bit 5
        rd(8'h40, ID0, "R1");
        rd(8'h44, ID1, "R1");
        rd(8'h18, 32'd0, "R10");
        rd(8'h20, 32'd0, "R10");

        // R9 inbound blocked while busy
        rx_valid = 1; rx_data = 8'hAA; rx_last = 1;
        tick();
        chk("R9", {31'b0, rx_ready}, 32'd0);
        rx_valid = 0; rx_last = 0;
        wr(8'h14, 32'h0);
        rd(8'h08, 32'd0, "R4");

        // R9/R8 five-byte frame
        rx_frame(5, 8'h10);
        rd(8'h0C, 32'd5, "R9");
        rd(8'h08, 32'd1, "R9");
        rd(8'h14, 32'd2, "R2");
        for (int i = 0; i < 5; i++) rd(8'h1C, 32'h10 + 32'(i), "R8");
        rd(8'h1C, 32'd0, "R8");
        rd(8'h0C, 32'd0, "R8");
        wr(8'h14, 32'h2);
        rd(8'h14, 32'd0, "R4");
        rd(8'h08, 32'd0, "R4");

        // R10 writes to read-only offsets
        wr(8'h0C, 32'd7);  rd(8'h0C, 32'd0, "R10");
        wr(8'h08, 32'd1);  rd(8'h08, 32'd0, "R10");
        wr(8'h00, 32'd5);  rd(8'h00, ID0, "R10");
        wr(8'h18, 32'd9);  rd(8'h18, 32'd0, "R10");

        // R12 data write with count 0
        wr(8'h20, 32'h55);
        chk("R12", {31'b0, tx_valid}, 32'd0);
        rd(8'h14, 32'd0, "R12");

        // R6 count limit
        wr(8'h10, 32'd17); rd(8'h10, 32'd0, "R6");
        wr(8'h10, 32'd16); rd(8'h10, 32'd16, "R6");
        wr(8'h10, 32'd4);  rd(8'h10, 32'd4, "R6");

        // R7 four-byte frame with back-pressure
        wr(8'h20, 32'hFFFF_FFA1);
        wr(8'h20, 32'h0000_01B2);
        wr(8'h20, 32'h0000_00C3);
        rd(8'h10, 32'd4, "R7");
        chk("R7", {31'b0, tx_valid}, 32'd0);
        wr(8'h20, 32'h0000_00D4);
        chk("R7", {31'b0, tx_valid}, 32'd1);
        chk("R7", {24'b0, tx_data}, 32'hA1);
        rd(8'h10, 32'd0, "R7");
        rd(8'h08, 32'd1, "R7");
        // R12 data writes ignored while sending
        wr(8'h10, 32'd2);
        wr(8'h20, 32'h77);
        rd(8'h10, 32'd2, "R12");
        tx_ready = 1;
        drain(4);
        chk("R7", {got[0], got[1], got[2], got[3]}, 32'hA1B2C3D4);
        wr(8'h20, 32'h31);
        wr(8'h20, 32'h32);
        drain(6);
        chk("R12", {16'b0, got[4], got[5]}, 32'h3132);

        // R4 priority
        wr(8'h14, 32'h1);
        rd(8'h08, 32'd0, "R4");
        rx_frame(1, 8'h5A);
        wr(8'h10, 32'd1);
        wr(8'h20, 32'h66);
        drain(7);
        chk("R12", {24'b0, got[6]}, 32'h66);
        rd(8'h14, 32'd3, "R4");
        wr(8'h14, 32'h3);
        rd(8'h14, 32'd2, "R4");
        wr(8'h14, 32'h8000_0002);
        rd(8'h14, 32'd0, "R4");
        rd(8'h0C, 32'd1, "R4");
        rd(8'h1C, 32'h5A, "R8");

        // R4/R3 soft reset and self-clearing test flag
        wr(8'h10, 32'd3);
        wr(8'h14, 32'h8000_0000);
        chk("R3", {31'b0, irq}, 32'd1);
        rd(8'h10, 32'd0, "R4");
        rd(8'h08, 32'd1, "R4");
        rd(8'h14, 32'h8000_0000, "R3");
        rd(8'h14, 32'd0, "R3");
        chk("R3", {31'b0, irq}, 32'd0);
        rd(8'h08, 32'd1, "R3");
        wr(8'h14, 32'h0);
        rd(8'h08, 32'd0, "R4");

        // R11 over-length frame, R9 count at limit blocks
        rx_frame(20, 8'h80);
        rd(8'h0C, 32'd16, "R11");
        wr(8'h14, 32'h2);
        rd(8'h08, 32'd0, "R9");
        chk("R9", {31'b0, rx_ready}, 32'd0);
        for (int i = 0; i < MAX; i++) rd(8'h1C, 32'h80 + 32'(i), "R11");
        rd(8'h0C, 32'd0, "R11");
        chk("R9", {31'b0, rx_ready}, 32'd1);

        // R7 full-length frame
        wr(8'h10, 32'd16);
        for (int i = 0; i < MAX; i++) wr(8'h20, 32'hE0 + 32'(i));
        drain(7 + MAX);
        for (int i = 0; i < MAX; i++) chk("R7", {24'b0, got[7 + i]}, 32'hE0 + 32'(i));
        repeat (3) tick();

        finished = 1;
        summary();
        $finish;
    end

endmodule